// File: doc/BRIEF.md
# Processor Status Flags and Interrupt Gate

This block keeps the eight-bit processor flag byte and decides, at each instruction boundary, whether a pending interrupt is taken and of which kind. The sequencer marks boundaries with a strobe, issues set-mask and clear-mask commands, and restores the whole byte through a write port when flags come back from the stack. When the block raises a take request, the sequencer runs its entry sequence and acknowledges the request. The acknowledge makes the block set its own interrupt-mask bit, so a second maskable request cannot nest inside the handler.

The mask comes up set after reset. Startup code can then configure peripherals that may be driving the maskable line in an undefined way, and no spurious service happens before the software clears the mask. The non-maskable input ignores the mask in every state, including the first instructions after reset. Bit 5 of the byte reads as one at all times. The arithmetic flags are stored and handed back but are never interpreted here.

Top module: `psg_top`

## Requirements
- R1: After reset the flag byte reads 8'h24 (bit 5 and the mask bit, bit 2, set; all other bits 0) and no take request is raised.
- R2: A flag write loads bits 7..6 and 4..0 from the write data, and bit 5 reads 1 whatever is written (writing 8'hDB reads back 8'hFB, writing 8'h00 reads back 8'h20). The new value is visible the cycle after the write.
- R3: A set-mask strobe makes bit 2 read 1 and a clear-mask strobe makes bit 2 read 0, from the next cycle on.
- R4: While bit 2 is 1, a low maskable request line does not cause a take request.
- R5: When bit 2 is 0 and the maskable line (active low) is low at a boundary strobe, a take request is raised with the kind output 0 (maskable).
- R6: A non-maskable request is taken with kind output 1 even while bit 2 is 1, including directly after reset.
- R7: The non-maskable input is detected on a high-to-low transition and stays latched until its take is acknowledged, even if the input rises again first. Holding the input low after the acknowledge does not cause another take.
- R8: When both kinds are pending at the same boundary, the non-maskable one is taken first.
- R9: A take request rises only in the cycle after a boundary strobe. It then stays high with its kind unchanged until it is acknowledged, and it falls in the cycle after the acknowledge.
- R10: Acknowledging a take request of either kind sets bit 2.
- R11: In a single cycle, set-mask outranks clear-mask, and both outrank the flag write for bit 2. A flag write of 8'h00 together with set-mask reads 8'h24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Strobe marking an instruction boundary |
| set_mask_i | input | 1 | Command that sets the interrupt mask |
| clr_mask_i | input | 1 | Command that clears the interrupt mask |
| flag_wr_i | input | 1 | Strobe that loads the flag byte from flag_wdata_i |
| flag_wdata_i | input | 8 | Flag byte to restore |
| irq_n_i | input | 1 | Maskable request, level, active low |
| nmi_n_i | input | 1 | Non-maskable request, falling-edge detected |
| ack_i | input | 1 | Sequencer acknowledges the take request |
| take_o | output | 1 | Take-interrupt request |
| take_nmi_o | output | 1 | Kind of the request: 1 non-maskable, 0 maskable |
| flags_o | output | 8 | Current flag byte |

## Verification
The hardest situation to reach is a non-maskable edge that arrives while the input is already low, or while a maskable request is competing for the same boundary. From the ports the latch is visible only through a later take. The stimulus therefore releases the input and lowers it again to create new edges. It holds the input low across an acknowledge to show that no second take appears, and it pulses the input for a single cycle long before any boundary to show that the event is latched. For priority, the stimulus first clears the mask with the maskable line low and then creates the edge, so both requests are pending at one strobe. Once the non-maskable take is acknowledged, the automatic mask setting blocks the maskable request until a clear-mask command lets it through.

// File: rtl/psg_pkg.sv
package psg_pkg;
  localparam int FLAG_W   = 8;
  localparam int MASK_POS = 2;
  localparam int TIED_POS = 5;
  localparam logic [FLAG_W-1:0] TIED_ONE    = {{(FLAG_W-1){1'b0}}, 1'b1} << TIED_POS;
  localparam logic [FLAG_W-1:0] MASK_ONE    = {{(FLAG_W-1){1'b0}}, 1'b1} << MASK_POS;
  localparam logic [FLAG_W-1:0] RESET_FLAGS = TIED_ONE | MASK_ONE;

  typedef enum logic {KIND_IRQ = 1'b0, KIND_NMI = 1'b1} int_kind_t;

  // Next flag byte: write port lowest, then set/clear, then interrupt entry.
  function automatic logic [FLAG_W-1:0] next_flags(
    input logic [FLAG_W-1:0] cur,
    input logic              wr_en,
    input logic [FLAG_W-1:0] wdata,
    input logic              set_m,
    input logic              clr_m,
    input logic              enter
  );
    logic [FLAG_W-1:0] n;
    n = wr_en ? wdata : cur;
    if (set_m)      n[MASK_POS] = 1'b1;
    else if (clr_m) n[MASK_POS] = 1'b0;
    if (enter)      n[MASK_POS] = 1'b1;
    n[TIED_POS] = 1'b1;
    return n;
  endfunction

  // Kind chosen at a boundary: non-maskable wins over maskable.
  function automatic int_kind_t pick_kind(input logic nmi_want);
    return nmi_want ? KIND_NMI : KIND_IRQ;
  endfunction
endpackage

// File: rtl/psg_flag_reg.sv
module psg_flag_reg
  import psg_pkg::*;
#(
  parameter int W = FLAG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         set_m,
  input  logic         clr_m,
  input  logic         enter,
  output logic [W-1:0] flags,
  output logic         mask
);
  logic [W-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= RESET_FLAGS;
    else        flags_q <= next_flags(flags_q, wr_en, wdata, set_m, clr_m, enter);
  end

  assign flags = flags_q;
  assign mask  = flags_q[MASK_POS];

  // R10: entry sets the mask
  a_r10_entry_sets_mask: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> mask);
  // R3 / R11: set outranks clear
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_m |=> mask);
  // R3: clear alone clears
  a_r3_clear_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_m && !set_m && !enter) |=> !mask);
  // R2: untouched byte holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !set_m && !clr_m && !enter) |=> $stable(flags));
endmodule

// File: rtl/psg_nmi_latch.sv
module psg_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic clear,
  output logic pending,
  output logic fall_evt
);
  logic prev_q;
  logic pend_q;

  assign fall_evt = prev_q & ~nmi_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_n;
      pend_q <= (pend_q & ~clear) | fall_evt;
    end
  end

  assign pending = pend_q;

  // R7: latched until acknowledged
  a_r7_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clear) |=> pending);
  // R7: a new edge always registers
  a_r7_edge_caught: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> pending);
endmodule

// File: rtl/psg_int_arbiter.sv
module psg_int_arbiter
  import psg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic nmi_pend,
  input  logic irq_n,
  input  logic mask,
  input  logic ack,
  output logic take,
  output logic take_nmi,
  output logic enter_evt,
  output logic nmi_clear
);
  logic      take_q;
  int_kind_t kind_q;
  logic      irq_want;
  logic      decide;

  assign irq_want  = ~irq_n & ~mask;
  assign decide    = boundary & ~take_q & (nmi_pend | irq_want);
  assign enter_evt = take_q & ack;
  assign nmi_clear = enter_evt & (kind_q == KIND_NMI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      kind_q <= KIND_IRQ;
    end else if (decide) begin
      take_q <= 1'b1;
      kind_q <= pick_kind(nmi_pend);
    end else if (enter_evt) begin
      take_q <= 1'b0;
    end
  end

  assign take     = take_q;
  assign take_nmi = (kind_q == KIND_NMI);

  // R9: rises only after a boundary strobe
  a_r9_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take) |-> $past(boundary));
  // R9: held with stable kind until acknowledged
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ack) |=> (take && $stable(take_nmi)));
  // R9: falls after acknowledge
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ack) |=> !take);
  // R4: a maskable take only when the mask was clear
  a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(take) && !take_nmi) |-> !$past(mask));
  // R8: non-maskable first
  a_r8_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(take) && $past(nmi_pend)) |-> take_nmi);
endmodule

// File: rtl/psg_top.sv
module psg_top
  import psg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              set_mask_i,
  input  logic              clr_mask_i,
  input  logic              flag_wr_i,
  input  logic [FLAG_W-1:0] flag_wdata_i,
  input  logic              irq_n_i,
  input  logic              nmi_n_i,
  input  logic              ack_i,
  output logic              take_o,
  output logic              take_nmi_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic mask_w;
  logic nmi_pend_w;
  logic nmi_fall_w;
  logic enter_w;
  logic nmi_clear_w;

  psg_flag_reg #(.W(FLAG_W)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (flag_wr_i),
    .wdata (flag_wdata_i),
    .set_m (set_mask_i),
    .clr_m (clr_mask_i),
    .enter (enter_w),
    .flags (flags_o),
    .mask  (mask_w)
  );

  psg_nmi_latch u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_n    (nmi_n_i),
    .clear    (nmi_clear_w),
    .pending  (nmi_pend_w),
    .fall_evt (nmi_fall_w)
  );

  psg_int_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .boundary  (boundary_i),
    .nmi_pend  (nmi_pend_w),
    .irq_n     (irq_n_i),
    .mask      (mask_w),
    .ack       (ack_i),
    .take      (take_o),
    .take_nmi  (take_nmi_o),
    .enter_evt (enter_w),
    .nmi_clear (nmi_clear_w)
  );

  // R6: a pending non-maskable event is taken at a boundary regardless of the mask
  a_r6_nmi_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && !take_o && nmi_pend_w) |=> (take_o && take_nmi_o));
  // R7: the edge event stays pending at least into the next cycle
  a_r7_fall_seen: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_fall_w |=> (nmi_pend_w || take_o));
endmodule

// File: tb/tb_psg_top.sv
`timescale 1ns/1ps
module tb_psg_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       boundary_i, set_mask_i, clr_mask_i, flag_wr_i;
  logic [7:0] flag_wdata_i;
  logic       irq_n_i, nmi_n_i, ack_i;
  logic       take_o, take_nmi_o;
  logic [7:0] flags_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int ack_delay = 0;
  bit exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  psg_top dut (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .set_mask_i(set_mask_i),
    .clr_mask_i(clr_mask_i), .flag_wr_i(flag_wr_i), .flag_wdata_i(flag_wdata_i),
    .irq_n_i(irq_n_i), .nmi_n_i(nmi_n_i), .ack_i(ack_i), .take_o(take_o),
    .take_nmi_o(take_nmi_o), .flags_o(flags_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // driver: expect one take of the given kind (1 = non-maskable)
  task automatic expect_take(input bit nmi, input string tag);
    exp_q.push_back(nmi);
    tag_q.push_back(tag);
  endtask

  task automatic pulse_boundary();
    @(negedge clk); boundary_i = 1'b1;
    @(negedge clk); boundary_i = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    repeat (2) @(negedge clk);
    while ((exp_q.size() != 0 || take_o || ack_i) && n < 50) begin
      @(negedge clk); n++;
    end
    check(n < 50, "R9 expected take never arrived", exp_q.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic no_take(input string tag);
    repeat (3) @(negedge clk);
    check(!take_o, tag, take_o, 0);
  endtask

  task automatic cmd(input bit s, input bit c, input bit w, input logic [7:0] d);
    @(negedge clk);
    set_mask_i = s; clr_mask_i = c; flag_wr_i = w; flag_wdata_i = d;
    @(negedge clk);
    set_mask_i = 0; clr_mask_i = 0; flag_wr_i = 0;
  endtask

  // monitor: pops expected kinds as takes appear, then acknowledges
  initial begin
    ack_i = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && take_o) begin
        bit k0;
        bit e;
        string t;
        k0 = take_nmi_o;
        for (int i = 0; i < ack_delay; i++) begin
          @(negedge clk);
          check(take_o && take_nmi_o == k0, "R9 request held until ack", {take_o, take_nmi_o}, {1'b1, k0});
        end
        if (exp_q.size() == 0) begin
          check(1'b0, "R4/R7/R9 unexpected take", k0, 2);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(k0 == e, t, k0, e);
        end
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
        check(!take_o, "R9 released after ack", take_o, 0);
        check(flags_o[2], "R10 ack sets mask", flags_o[2], 1);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 0; boundary_i = 0; set_mask_i = 0; clr_mask_i = 0; flag_wr_i = 0;
    flag_wdata_i = 8'h00; irq_n_i = 1; nmi_n_i = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(flags_o == 8'h24, "R1 reset flags", flags_o, 8'h24);
    check(!take_o, "R1 no take after reset", take_o, 0);

    // R6: non-maskable right after reset, mask set
    @(negedge clk); nmi_n_i = 0;
    @(negedge clk);
    expect_take(1'b1, "R6 nmi taken while masked");
    pulse_boundary();
    wait_idle();
    check(flags_o == 8'h24, "R6 mask still set", flags_o, 8'h24);

    // R7: input still low, no retake
    pulse_boundary();
    no_take("R7 held low no retake");
    @(negedge clk); nmi_n_i = 1;

    // R4: maskable blocked while masked
    @(negedge clk); irq_n_i = 0;
    pulse_boundary();
    no_take("R4 irq blocked by mask");

    // R3 clear mask, R5 irq taken
    cmd(0, 1, 0, 8'h00);
    check(flags_o == 8'h20, "R3 clear mask", flags_o, 8'h20);
    expect_take(1'b0, "R5 irq taken kind 0");
    pulse_boundary();
    wait_idle();
    check(flags_o[2], "R10 mask after irq", flags_o[2], 1);
    @(negedge clk); irq_n_i = 1;

    // R3 set mask
    cmd(0, 1, 0, 8'h00);
    cmd(1, 0, 0, 8'h00);
    check(flags_o == 8'h24, "R3 set mask", flags_o, 8'h24);
    // R11 set and clear together
    cmd(1, 1, 0, 8'h00);
    check(flags_o == 8'h24, "R11 set beats clear", flags_o, 8'h24);

    // R2 flag write, bit 5 tied
    cmd(0, 0, 1, 8'hDB);
    check(flags_o == 8'hFB, "R2 write DB", flags_o, 8'hFB);
    cmd(0, 0, 1, 8'h00);
    check(flags_o == 8'h20, "R2 write 00", flags_o, 8'h20);
    cmd(1, 0, 1, 8'h00);
    check(flags_o == 8'h24, "R11 set beats write", flags_o, 8'h24);

    // R7 latch: one-cycle pulse long before boundary; R9 no take without boundary
    @(negedge clk); nmi_n_i = 0;
    @(negedge clk); nmi_n_i = 1;
    no_take("R9 no take without boundary");
    repeat (5) @(negedge clk);
    ack_delay = 3;
    expect_take(1'b1, "R7 latched pulse taken");
    pulse_boundary();
    wait_idle();
    ack_delay = 0;

    // R7 fresh edge after release is taken
    @(negedge clk); nmi_n_i = 0;
    expect_take(1'b1, "R7 new edge taken");
    pulse_boundary();
    wait_idle();
    @(negedge clk); nmi_n_i = 1;

    // R8 priority: both pending
    cmd(0, 1, 0, 8'h00);
    @(negedge clk); irq_n_i = 0;
    @(negedge clk); nmi_n_i = 0;
    expect_take(1'b1, "R8 nmi before irq");
    pulse_boundary();
    wait_idle();
    pulse_boundary();
    no_take("R4 irq blocked after nmi entry");
    cmd(0, 1, 0, 8'h00);
    expect_take(1'b0, "R8 irq after nmi served");
    pulse_boundary();
    wait_idle();
    irq_n_i = 1; nmi_n_i = 1;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 all expected takes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule